// File: doc/BRIEF.md
# Four-Channel Converter Code Register Bank

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host drives an 8-bit parallel data word, a 2-bit channel number and active-low chip-enable and write strobes. The block keeps one code register per channel and presents all four codes at once to the analog stage, together with a per-channel output-enable flag and a per-channel power-down flag.

A write takes place on the low-to-high edge of the write strobe. The strobe is first synchronised into the system clock, and the edge is detected there. Chip enable, channel number and data are sampled in the clock cycle in which the edge is detected. The block also has an active-low preset input and an active-low power-down input. Each passes through a synchroniser and a low-time filter, so that short glitches are ignored. A held preset loads mid-scale into every register. A held power-down turns every output off and has priority over everything else, but it leaves the stored codes untouched.

Top module: `dac_code_bank`

## Requirements
- R1: The channel number selects the register as follows: 0 (binary 00) is channel 0, 1 is channel 1, 2 is channel 2 and 3 is channel 3. Channel k's code appears on `codeBus[8k+7:8k]`.
- R2: A write happens only on the rising edge of `wrN`. While `wrN` falls or stays low, no code changes.
- R3: When `ceN` is high at the detected edge of `wrN`, no register changes.
- R4: When `clrN` is held low (and `pdN` is high) for longer than the filter time, every register reads 8'h80. After `arstN` is released, every register also reads 8'h80.
- R5: When `pdN` is held low longer than the filter time, `outEn` becomes all zero and `chanPwrDn` becomes all one.
- R6: During power-down, writes and presets are ignored. When power-down is released, the outputs are enabled again with the codes stored before it.
- R7: A write changes only the selected channel. The other three codes keep their values.
- R8: A low pulse on `clrN` or `pdN` shorter than `MIN_LOW_CYC` clock cycles has no effect.
- R9: Bit 0 of `dataIn` is the least significant bit of the stored code and bit 7 is the most significant bit, with no reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arstN | input | 1 | Asynchronous system reset, active low |
| dataIn | input | 8 | Code to write |
| chanSel | input | 2 | Target channel number |
| ceN | input | 1 | Chip enable, active low |
| wrN | input | 1 | Write strobe, write on rising edge |
| clrN | input | 1 | Preset-to-mid-scale request, active low |
| pdN | input | 1 | Power-down request, active low |
| codeBus | output | 32 | Four codes, channel k at bits 8k+7:8k |
| outEn | output | 4 | Per-channel analog output enable |
| chanPwrDn | output | 4 | Per-channel power-down flag |

## Verification
The bench builds the block with `MIN_LOW_CYC` set to 8 and two synchroniser stages. With these values a 3-cycle glitch and a 20-cycle held pulse fall on opposite sides of the filter threshold, within a short run. The edge-to-register latency is then only a few cycles, so the bench can check registers both while the strobe is low and after it rises. It can also overlap power-down with writes and with presets, and confirm that the codes survive.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  typedef struct packed {
    logic load;
    logic preset;
    logic powerDown;
  } bank_stb_t;
endpackage

// File: rtl/dac_bank_sync.sv
module dac_bank_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dac_bank_lowfilt.sv
module dac_bank_lowfilt #(
  parameter int MIN_LOW_CYC = 63
) (
  input  logic clk,
  input  logic arstN,
  input  logic lvlN,
  output logic active
);
  localparam int CNT_W = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW_CYC);
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)              lowCnt <= '0;
    else if (lvlN)           lowCnt <= '0;
    else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
  end
  assign active = (lowCnt == CNT_MAX);
endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
  import dac_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 63
) (
  input  logic      clk,
  input  logic      arstN,
  input  logic      ceN,
  input  logic      wrN,
  input  logic      clrN,
  input  logic      pdN,
  output bank_stb_t stb
);
  logic wrSync, clrSync, pdSync;
  logic wrPrev;
  logic clrActive, pdActive;
  logic wrRise;

  dac_bank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uWrSync (
    .clk(clk), .arstN(arstN), .din(wrN), .dout(wrSync));
  dac_bank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uClrSync (
    .clk(clk), .arstN(arstN), .din(clrN), .dout(clrSync));
  dac_bank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uPdSync (
    .clk(clk), .arstN(arstN), .din(pdN), .dout(pdSync));

  dac_bank_lowfilt #(.MIN_LOW_CYC(MIN_LOW_CYC)) uClrFilt (
    .clk(clk), .arstN(arstN), .lvlN(clrSync), .active(clrActive));
  dac_bank_lowfilt #(.MIN_LOW_CYC(MIN_LOW_CYC)) uPdFilt (
    .clk(clk), .arstN(arstN), .lvlN(pdSync), .active(pdActive));

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) wrPrev <= 1'b1;
    else        wrPrev <= wrSync;
  end
  assign wrRise = wrSync & ~wrPrev;

  // priority: power-down, then preset, then write
  always_comb begin
    stb.powerDown = pdActive;
    stb.preset    = clrActive & ~pdActive;
    stb.load      = wrRise & ~ceN & ~pdActive & ~clrActive;
  end
endmodule

// File: rtl/dac_bank_dp.sv
module dac_bank_dp
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CHAN_N = 4,
  parameter int SEL_W  = 2
) (
  input  logic                     clk,
  input  logic                     arstN,
  input  bank_stb_t                stb,
  input  logic [SEL_W-1:0]         selIdx,
  input  logic [CODE_W-1:0]        dataIn,
  output logic [CHAN_N*CODE_W-1:0] codeBus,
  output logic [CHAN_N-1:0]        outEn,
  output logic [CHAN_N-1:0]        chanPwrDn
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  for (genvar g = 0; g < CHAN_N; g++) begin : gChan
    logic [CODE_W-1:0] codeReg;
    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN)                                   codeReg <= MID_CODE;
      else if (stb.preset)                          codeReg <= MID_CODE;
      else if (stb.load && selIdx == SEL_W'(g))     codeReg <= dataIn;
    end
    assign codeBus[g*CODE_W +: CODE_W] = codeReg;

    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) begin
        outEn[g]     <= 1'b1;
        chanPwrDn[g] <= 1'b0;
      end else begin
        outEn[g]     <= ~stb.powerDown;
        chanPwrDn[g] <= stb.powerDown;
      end
    end
  end
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
  import dac_bank_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CHAN_N      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 63,
  localparam int SEL_W      = $clog2(CHAN_N)
) (
  input  logic                     clk,
  input  logic                     arstN,
  input  logic [CODE_W-1:0]        dataIn,
  input  logic [SEL_W-1:0]         chanSel,
  input  logic                     ceN,
  input  logic                     wrN,
  input  logic                     clrN,
  input  logic                     pdN,
  output logic [CHAN_N*CODE_W-1:0] codeBus,
  output logic [CHAN_N-1:0]        outEn,
  output logic [CHAN_N-1:0]        chanPwrDn
);
  bank_stb_t ctrlStb;

  dac_bank_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW_CYC(MIN_LOW_CYC)) uCtrl (
    .clk(clk), .arstN(arstN), .ceN(ceN), .wrN(wrN), .clrN(clrN), .pdN(pdN),
    .stb(ctrlStb));

  dac_bank_dp #(.CODE_W(CODE_W), .CHAN_N(CHAN_N), .SEL_W(SEL_W)) uDp (
    .clk(clk), .arstN(arstN), .stb(ctrlStb), .selIdx(chanSel), .dataIn(dataIn),
    .codeBus(codeBus), .outEn(outEn), .chanPwrDn(chanPwrDn));
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CHAN_N = 4,
  parameter int SEL_W  = 2
) (
  input logic                     clk,
  input logic                     arstN,
  input bank_stb_t                stb,
  input logic                     ceN,
  input logic [SEL_W-1:0]         chanSel,
  input logic [CODE_W-1:0]        dataIn,
  input logic [CHAN_N*CODE_W-1:0] codeBus,
  input logic [CHAN_N-1:0]        outEn,
  input logic [CHAN_N-1:0]        chanPwrDn
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  a_r3_ce_blocks: assert property (@(posedge clk) disable iff (!arstN)
    (ceN && !stb.preset) |=> $stable(codeBus));

  a_r6_pd_holds: assert property (@(posedge clk) disable iff (!arstN)
    stb.powerDown |=> $stable(codeBus));

  a_r4_preset_mid: assert property (@(posedge clk) disable iff (!arstN)
    stb.preset |=> codeBus == {CHAN_N{MID_CODE}});

  a_r5_outputs_off: assert property (@(posedge clk) disable iff (!arstN)
    stb.powerDown |=> (outEn == '0 && chanPwrDn == '1));

  for (genvar g = 0; g < CHAN_N; g++) begin : gChk
    a_r1_select_write: assert property (@(posedge clk) disable iff (!arstN)
      (stb.load && !stb.preset && chanSel == SEL_W'(g))
        |=> codeBus[g*CODE_W +: CODE_W] == $past(dataIn));
    a_r7_others_kept: assert property (@(posedge clk) disable iff (!arstN)
      (stb.load && !stb.preset && chanSel != SEL_W'(g))
        |=> $stable(codeBus[g*CODE_W +: CODE_W]));
  end
endmodule

bind dac_code_bank dac_bank_chk #(.CODE_W(CODE_W), .CHAN_N(CHAN_N), .SEL_W(SEL_W)) uChk (
  .clk(clk), .arstN(arstN), .stb(ctrlStb), .ceN(ceN), .chanSel(chanSel),
  .dataIn(dataIn), .codeBus(codeBus), .outEn(outEn), .chanPwrDn(chanPwrDn));

// File: tb/dac_code_bank_test.sv
module dac_code_bank_test;
  logic        clk = 1'b0;
  logic        arstN = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [1:0]  chanSel = '0;
  logic        ceN = 1'b1, wrN = 1'b1, clrN = 1'b1, pdN = 1'b1;
  logic [31:0] codeBus;
  logic [3:0]  outEn, chanPwrDn;
  int          checkCnt = 0, failCnt = 0;
  bit          done = 1'b0;
  logic [31:0] expCodes;

  always #4 clk = ~clk;

  dac_code_bank #(.SYNC_STAGES(2), .MIN_LOW_CYC(8)) uut (
    .clk(clk), .arstN(arstN), .dataIn(dataIn), .chanSel(chanSel), .ceN(ceN),
    .wrN(wrN), .clrN(clrN), .pdN(pdN), .codeBus(codeBus), .outEn(outEn),
    .chanPwrDn(chanPwrDn));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [1:0] ch, input logic [7:0] d, input logic ce);
    chanSel = ch; dataIn = d; ceN = ce;
    wrN = 1'b0; cyc(4);
    check("R2 no change while strobe low", codeBus, expCodes);
    wrN = 1'b1; cyc(6);
    ceN = 1'b1;
  endtask

  task automatic t_reset_state;
    check("R4 mid-scale after system reset", codeBus, {4{8'h80}});
    check("R5 outputs enabled after reset", {outEn, chanPwrDn}, {4'hF, 4'h0});
  endtask

  task automatic t_channel_map;
    for (int c = 0; c < 4; c++) begin
      doWrite(2'(c), 8'h11 * 8'(c + 1), 1'b0);
      expCodes[c*8 +: 8] = 8'h11 * 8'(c + 1);
      check("R1 R7 select map, others kept", codeBus, expCodes);
    end
  endtask

  task automatic t_bit_order;
    doWrite(2'd2, 8'h01, 1'b0);
    expCodes[23:16] = 8'h01;
    check("R9 bit0 is LSB", codeBus, expCodes);
    doWrite(2'd2, 8'h80, 1'b0);
    expCodes[23:16] = 8'h80;
    check("R9 bit7 is MSB", codeBus, expCodes);
    doWrite(2'd1, 8'hA5, 1'b0);
    expCodes[15:8] = 8'hA5;
    check("R7 write ch1 only", codeBus, expCodes);
  endtask

  task automatic t_ce_block;
    doWrite(2'd0, 8'h3C, 1'b1);
    check("R3 ceN high blocks write", codeBus, expCodes);
  endtask

  task automatic t_preset;
    clrN = 1'b0; cyc(3); clrN = 1'b1; cyc(10);
    check("R8 short preset pulse ignored", codeBus, expCodes);
    clrN = 1'b0; cyc(20);
    expCodes = {4{8'h80}};
    check("R4 held preset loads mid-scale", codeBus, expCodes);
    clrN = 1'b1; cyc(5);
    check("R4 mid-scale kept after release", codeBus, expCodes);
  endtask

  task automatic t_power_down;
    doWrite(2'd3, 8'hC3, 1'b0);
    expCodes[31:24] = 8'hC3;
    pdN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cyc(1);
      check("R8 short pd pulse ignored", {outEn, chanPwrDn}, {4'hF, 4'h0});
    end
    pdN = 1'b1; cyc(10);
    check("R8 outputs on after short pd", {outEn, chanPwrDn}, {4'hF, 4'h0});
    pdN = 1'b0; cyc(20);
    check("R5 pd disables outputs", {outEn, chanPwrDn}, {4'h0, 4'hF});
    doWrite(2'd3, 8'h5A, 1'b0);
    check("R6 write ignored in pd", codeBus, expCodes);
    clrN = 1'b0; cyc(20);
    check("R6 preset ignored in pd", codeBus, expCodes);
    clrN = 1'b1; cyc(5);
    pdN = 1'b1; cyc(8);
    check("R6 outputs back on", {outEn, chanPwrDn}, {4'hF, 4'h0});
    check("R6 codes kept across pd", codeBus, expCodes);
  endtask

  initial begin
    expCodes = {4{8'h80}};
    cyc(3); arstN = 1'b1; cyc(3);
    t_reset_state();
    t_channel_map();
    t_bit_order();
    t_ce_block();
    t_preset();
    t_power_down();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule